// File: doc/BRIEF.md
# Inter-Processor Mailbox Port

This block is one processor-facing side of a mailbox that carries 32-bit words between two processors. The local processor reaches it over a simple single-cycle register bus. A bus write to the transmit data word pushes into an outgoing queue, which the peer drains over a valid/ready stream. Words arriving from the peer over a second valid/ready stream fill an incoming queue, and a bus read of the receive data word pops it.

Around the two queues sit a status word, a sticky error word, two programmable fill thresholds, and an interrupt group of three registers with one bit layout: captured, enable and masked. A single interrupt line is raised whenever any enabled captured bit is set. A control word flushes either queue in one cycle.

All register reads are combinational in the cycle that `bus_rd` is high. Side effects take place at the clock edge that closes the access: a pop, an error capture or a clear.

Top module: `mbx_port`

## Requirements
- R1: After reset, both queues are empty. The status word reads 0x5 (bit0 receive-empty, bit2 send-level), the captured interrupt bits read 0, `irq` is low, `tx_valid` is low and `rx_ready` is high.
- R2: A bus write to offset 0x00 appends the write data to the send queue. The peer sees the words on `tx_data` in write order, and one word leaves at each cycle where `tx_valid` and `tx_ready` are both high.
- R3: Words accepted from `rx_data` come back in arrival order from bus reads of offset 0x08, and each read pops one word. Status bit0 is 1 exactly when the receive queue is empty.
- R4: Status bit1 is 1 exactly when the send queue holds DEPTH words. A bus write to 0x00 while the queue is full discards the data and sets error bit1 (offset 0x14).
- R5: A bus read of 0x08 while the receive queue is empty returns 0, pops nothing and sets error bit0. Error bits stay set until a bus write to 0x14 with a 1 in that bit position clears them.
- R6: Status bit2 is 1 exactly when the send queue count is less than or equal to the send threshold (offset 0x18).
- R7: Status bit3 is 1 exactly when the receive queue count is strictly greater than the receive threshold (offset 0x1C).
- R8: Each threshold register keeps only its low log2(DEPTH) bits. A readback returns those bits, zero-extended.
- R9: Captured interrupt bits (offset 0x20) use bit0 for send-level, bit1 for receive-level and bit2 for error. A level bit is set one cycle after its status condition rises, and the error bit is set one cycle after any error event. A bit stays set until a bus write to 0x20 with a 1 in that bit position. A set that arrives in the same cycle as a clear wins.
- R10: The masked register (0x28) reads as captured AND enable (0x24). `irq` is high exactly when the masked value is nonzero.
- R11: A bus write to control (0x2C) with bit0 set empties the send queue, and with bit1 set empties the receive queue, at the edge of that write. A clear of one queue leaves the other queue untouched.
- R12: `rx_ready` is low exactly when the receive queue holds DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid in the cycle of the read |
| tx_valid | output | 1 | Send queue has a word for the peer |
| tx_ready | input | 1 | Peer accepts the word on `tx_data` |
| tx_data | output | 32 | Head word of the send queue |
| rx_valid | input | 1 | Peer offers a word |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | 32 | Word offered by the peer |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the port with DEPTH = 4, which gives two-bit thresholds. At that size it can sweep every threshold value against every fill level from empty to full for both queues, and check each status flag against a comparison computed in the bench. The small depth also brings the full and empty boundaries within a few bus accesses. This lets the discard on write-when-full, the zero return on read-when-empty, the queue flushes and the edge-captured interrupt sequence each be driven to completion directly.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int BUS_AW = 6;
    localparam int BUS_DW = 32;

    // Register offsets; software decodes these, so they are fixed.
    typedef enum logic [BUS_AW-1:0] {
        OFS_TXD  = 6'h00,
        OFS_RXD  = 6'h08,
        OFS_STAT = 6'h10,
        OFS_ERR  = 6'h14,
        OFS_STHR = 6'h18,
        OFS_RTHR = 6'h1C,
        OFS_ICAP = 6'h20,
        OFS_IEN  = 6'h24,
        OFS_IMSK = 6'h28,
        OFS_CTRL = 6'h2C
    } mbx_ofs_e;

    // Interrupt bit layout shared by capture, enable and masked words.
    typedef struct packed {
        logic fault;
        logic rx_lvl;
        logic tx_lvl;
    } mbx_irq_t;

    // Status word layout.
    typedef struct packed {
        logic rx_lvl;
        logic tx_lvl;
        logic tx_full;
        logic rx_empty;
    } mbx_stat_t;

    // Sticky error layout.
    typedef struct packed {
        logic wr_full;
        logic rd_empty;
    } mbx_err_t;

    function automatic logic [BUS_DW-1:0] zext4(input logic [3:0] v);
        return {{(BUS_DW-4){1'b0}}, v};
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= wdata;
    end

    assign head  = mem[rp];
    assign level = cnt;
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    p_push_has_room_r2: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_pop_has_data_r3: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    p_flush_empties_r11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0));

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int         N         = 3,
    parameter logic [N-1:0] PREV_INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] enable,
    output logic [N-1:0] captured,
    output logic [N-1:0] masked,
    output logic         req
);
    logic [N-1:0] prev_q, cap_q, set_v, clr_v;

    always_comb begin
        set_v = (cond & ~prev_q) | evt;
        clr_v = clr_we ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= PREV_INIT;
            cap_q  <= '0;
        end else begin
            prev_q <= cond;
            cap_q  <= (cap_q & ~clr_v) | set_v;
        end
    end

    assign captured = cap_q;
    assign masked   = cap_q & enable;
    assign req      = |masked;

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((captured & $past(set_v)) == $past(set_v)));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr_we && captured != '0) |=> ((captured & $past(captured)) == $past(captured)));

endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BUS_DW-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BUS_DW-1:0] rx_data,
    output logic              irq
);
    localparam int TW = $clog2(DEPTH);
    localparam int CW = TW + 1;

    logic [CW-1:0]     tx_lvl, rx_lvl;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [BUS_DW-1:0] rx_head;
    logic [TW-1:0]     sthr_q, rthr_q;
    mbx_irq_t          ien_q, icap, imsk;
    mbx_err_t          err_q;
    mbx_stat_t         stat;

    logic wr_txd, rd_rxd, wr_ctrl, wr_err, wr_icap;
    logic tx_push, tx_pop, rx_push, rx_pop, ev_wof, ev_roe;

    always_comb begin
        wr_txd  = bus_wr && (bus_addr == OFS_TXD);
        rd_rxd  = bus_rd && (bus_addr == OFS_RXD);
        wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
        wr_err  = bus_wr && (bus_addr == OFS_ERR);
        wr_icap = bus_wr && (bus_addr == OFS_ICAP);
        tx_push = wr_txd && !tx_full;
        ev_wof  = wr_txd && tx_full;
        rx_pop  = rd_rxd && !rx_empty;
        ev_roe  = rd_rxd && rx_empty;
        tx_pop  = !tx_empty && tx_ready;
        rx_push = rx_valid && !rx_full;
    end

    mbx_fifo #(.WIDTH(BUS_DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(wr_ctrl && bus_wdata[0]),
        .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
        .head(tx_data), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    mbx_fifo #(.WIDTH(BUS_DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(wr_ctrl && bus_wdata[1]),
        .push(rx_push), .wdata(rx_data), .pop(rx_pop),
        .head(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    assign tx_valid = !tx_empty;
    assign rx_ready = !rx_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            sthr_q <= '0;
            rthr_q <= '0;
            ien_q  <= '0;
            err_q  <= '0;
        end else begin
            if (bus_wr && bus_addr == OFS_STHR) sthr_q <= bus_wdata[TW-1:0];
            if (bus_wr && bus_addr == OFS_RTHR) rthr_q <= bus_wdata[TW-1:0];
            if (bus_wr && bus_addr == OFS_IEN)  ien_q  <= mbx_irq_t'(bus_wdata[2:0]);
            err_q <= mbx_err_t'((err_q & ~(wr_err ? bus_wdata[1:0] : 2'b00))
                                | {ev_wof, ev_roe});
        end
    end

    always_comb begin
        stat.rx_empty = rx_empty;
        stat.tx_full  = tx_full;
        stat.tx_lvl   = (tx_lvl <= {1'b0, sthr_q});
        stat.rx_lvl   = (rx_lvl >  {1'b0, rthr_q});
    end

    mbx_irq #(.N(3), .PREV_INIT(3'b001)) u_irq (
        .clk(clk), .rst(rst),
        .cond({1'b0, stat.rx_lvl, stat.tx_lvl}),
        .evt({ev_roe || ev_wof, 2'b00}),
        .clr_we(wr_icap), .clr_mask(bus_wdata[2:0]),
        .enable(ien_q), .captured(icap), .masked(imsk), .req(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_RXD:  bus_rdata = rx_empty ? '0 : rx_head;
                OFS_STAT: bus_rdata = zext4(stat);
                OFS_ERR:  bus_rdata = zext4({2'b00, err_q});
                OFS_STHR: bus_rdata = BUS_DW'(sthr_q);
                OFS_RTHR: bus_rdata = BUS_DW'(rthr_q);
                OFS_ICAP: bus_rdata = zext4({1'b0, icap});
                OFS_IEN:  bus_rdata = zext4({1'b0, ien_q});
                OFS_IMSK: bus_rdata = zext4({1'b0, imsk});
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr_err) |=> ((err_q & $past(err_q)) == $past(err_q)));
    p_roe_no_pop_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_rxd && rx_empty && !rx_valid) |=> rx_empty);
    p_wof_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_txd && tx_full) |=> err_q.wr_full);
    p_rx_backpressure_r12: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> !rx_ready);

endmodule

// File: tb/mbx_port_test.sv
module mbx_port_test;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdat = '0, rdata;
    logic        tx_valid, tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b0, rx_ready;
    logic [31:0] rx_data = '0;
    logic        irq;

    always #10 clk = ~clk;

    mbx_port #(.DEPTH(D)) uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdat), .bus_rdata(rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic bwr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdat = d; wr = 1'b1;
        @(posedge clk); #1 wr = 1'b0;
    endtask

    task automatic brd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        #2 d = rdata;
        @(posedge clk); #1 rd = 1'b0;
    endtask

    task automatic rxpush(input logic [31:0] d);
        @(negedge clk); rx_valid = 1'b1; rx_data = d;
        @(posedge clk); #1 rx_valid = 1'b0;
    endtask

    task automatic txtake(input string req, input logic [31:0] exp);
        @(negedge clk);
        chk(req, 32'(tx_valid), 32'd1);
        chk(req, tx_data, exp);
        tx_ready = 1'b1;
        @(posedge clk); #1 tx_ready = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        brd(6'h10, v); chk("R1 status", v, 32'h5);
        brd(6'h20, v); chk("R1 captured", v, 32'h0);
        @(negedge clk);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 rx_ready", 32'(rx_ready), 1);

        // R6 / R4 sweep: send threshold against every send fill level
        for (int t = 0; t < D; t++) begin
            bwr(6'h2C, 32'h1);
            bwr(6'h18, 32'(t));
            for (int n = 0; n <= D; n++) begin
                brd(6'h10, v);
                chk("R6 send level", 32'(v[2]), 32'(n <= t));
                chk("R4 send full", 32'(v[1]), 32'(n == D));
                if (n < D) bwr(6'h00, 32'h100 + 32'(n));
            end
        end

        // R8 threshold keeps low bits only
        bwr(6'h18, 32'hFFFF_FFF6); brd(6'h18, v); chk("R8 send thr", v, 32'h2);
        bwr(6'h1C, 32'h0000_0107); brd(6'h1C, v); chk("R8 recv thr", v, 32'h3);

        // R2 ordering on the peer stream
        bwr(6'h2C, 32'h1);
        bwr(6'h00, 32'hA1); bwr(6'h00, 32'hB2); bwr(6'h00, 32'hC3);
        txtake("R2 order", 32'hA1);
        txtake("R2 order", 32'hB2);
        txtake("R2 order", 32'hC3);
        @(negedge clk); chk("R2 drained", 32'(tx_valid), 0);

        // R4 write on full discards and flags
        bwr(6'h14, 32'h3);
        for (int i = 0; i < D; i++) bwr(6'h00, 32'h50 + 32'(i));
        bwr(6'h00, 32'hDEAD);
        brd(6'h14, v); chk("R4 error bit1", v, 32'h2);
        for (int i = 0; i < D; i++) txtake("R4 kept words", 32'h50 + 32'(i));
        @(negedge clk); chk("R4 discard", 32'(tx_valid), 0);

        // R5 read on empty
        brd(6'h08, v); chk("R5 zero data", v, 32'h0);
        brd(6'h14, v); chk("R5 error both", v, 32'h3);
        bwr(6'h14, 32'h1); brd(6'h14, v); chk("R5 clear bit0", v, 32'h2);
        bwr(6'h14, 32'h2); brd(6'h14, v); chk("R5 clear bit1", v, 32'h0);

        // R7 / R12 sweep: receive threshold against every receive fill level
        for (int t = 0; t < D; t++) begin
            bwr(6'h2C, 32'h2);
            bwr(6'h1C, 32'(t));
            for (int n = 0; n <= D; n++) begin
                brd(6'h10, v);
                chk("R7 recv level", 32'(v[3]), 32'(n > t));
                chk("R3 recv empty", 32'(v[0]), 32'(n == 0));
                @(negedge clk);
                chk("R12 rx_ready", 32'(rx_ready), 32'(n < D));
                if (n < D) rxpush(32'h200 + 32'(n));
            end
        end

        // R3 ordering of reads
        bwr(6'h2C, 32'h2);
        rxpush(32'h11); rxpush(32'h22); rxpush(32'h33);
        brd(6'h08, v); chk("R3 order", v, 32'h11);
        brd(6'h08, v); chk("R3 order", v, 32'h22);
        brd(6'h08, v); chk("R3 order", v, 32'h33);
        brd(6'h10, v); chk("R3 empty again", 32'(v[0]), 1);

        // R11 independent flushes
        bwr(6'h00, 32'h7); bwr(6'h00, 32'h8);
        rxpush(32'h9); rxpush(32'hA);
        bwr(6'h2C, 32'h1);
        @(negedge clk); chk("R11 send flushed", 32'(tx_valid), 0);
        brd(6'h10, v); chk("R11 recv kept", 32'(v[0]), 0);
        bwr(6'h2C, 32'h2);
        brd(6'h10, v); chk("R11 recv flushed", 32'(v[0]), 1);

        // R9 / R10 interrupt capture, masking and clearing
        bwr(6'h14, 32'h3);
        bwr(6'h24, 32'h0);
        bwr(6'h18, 32'h0);
        bwr(6'h1C, 32'h1);
        tick();
        bwr(6'h20, 32'h7);
        brd(6'h20, v); chk("R9 cleared", v, 32'h0);
        rxpush(32'h61);
        tick();
        brd(6'h20, v); chk("R9 no rise at count 1", v, 32'h0);
        rxpush(32'h62);
        tick();
        brd(6'h20, v); chk("R9 recv rise", v, 32'h2);
        brd(6'h28, v); chk("R10 masked off", v, 32'h0);
        @(negedge clk); chk("R10 irq off", 32'(irq), 0);
        bwr(6'h24, 32'h2);
        brd(6'h28, v); chk("R10 masked on", v, 32'h2);
        @(negedge clk); chk("R10 irq on", 32'(irq), 1);
        bwr(6'h20, 32'h2);
        brd(6'h20, v); chk("R9 w1c", v, 32'h0);
        @(negedge clk); chk("R10 irq after clear", 32'(irq), 0);
        brd(6'h08, v); chk("R3 pop", v, 32'h61);
        brd(6'h08, v); chk("R3 pop", v, 32'h62);
        brd(6'h08, v);
        tick();
        brd(6'h20, v); chk("R9 error capture", v, 32'h4);
        bwr(6'h24, 32'h4);
        @(negedge clk); chk("R10 irq error", 32'(irq), 1);
        bwr(6'h20, 32'h4);
        bwr(6'h00, 32'h71);
        tick();
        brd(6'h20, v); chk("R9 send level fell only", v, 32'h0);
        txtake("R2 single", 32'h71);
        tick();
        brd(6'h20, v); chk("R9 send rise", v, 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule